// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Unit

The unit holds two alarm settings, each made of four bytes (seconds, minutes, hours, day/date). Once per second, on the cycle where the external timekeeping chain pulses `sec_tick` and presents its new count, each alarm is compared against the live counters. A field whose bit 7 is set drops out of the comparison. Masking the day/date field gives a daily alarm, and masking every field gives an event every second.

A successful comparison raises that alarm's flag in the status byte. The enable bits do not gate this. A shared low-true output pin goes low while any flag is set together with its enable bit. A routing bit in the control byte can instead hand the pin to an externally generated square wave.

Firmware reaches the alarm, control and status bytes through a simple byte-wide port. Reads are combinational and writes are synchronous. The alarm bytes have no reset. They keep whatever they hold until written, and they serve as plain storage while their alarm is disabled.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset the control byte (address 8) reads 04h, the status byte (address 9) reads 00h and `alarm_int_n` is high.
- R2: Reset leaves the eight alarm bytes unchanged; a value written before a reset reads back the same after it.
- R3: On a clock edge where `sec_tick` is 1, an alarm whose unmasked fields all match sets its status flag (bit 0 for alarm 0, bit 1 for alarm 1). A field matches when bits 6:0 equal bits 6:0 of the live counter. The flag is set whether or not its enable is 1. Without `sec_tick`, no flag is set.
- R4: Bit 7 of any alarm byte masks that field; with all four fields masked the flag is set on every tick.
- R5: A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1, so 00h clears both. A matching tick in the same cycle wins, and the flag ends up set.
- R6: With control bit 2 set, `alarm_int_n` is low exactly while some flag is set with its enable (control bit 0 for alarm 0, bit 1 for alarm 1).
- R7: With control bit 2 clear, `alarm_int_n` follows `sqw_in`.
- R8: Clearing a flag releases `alarm_int_n` and leaves the alarm armed, so the next match sets the flag again.
- R9: Addresses 0-3 hold alarm 0 (seconds, minutes, hours, day/date) and 4-7 hold alarm 1, all 8 bits readable. Control bits 7:3 and status bits 7:2 read 0. Other addresses read 00h and ignore writes.
- R10: Clearing an enable bit releases `alarm_int_n` while the flag itself stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (control and status only) |
| sec_tick | input | 1 | One-cycle pulse when the live counters take a new second |
| live_sec | input | 8 | Live seconds count |
| live_min | input | 8 | Live minutes count |
| live_hour | input | 8 | Live hours count |
| live_day | input | 8 | Live day/date count |
| sqw_in | input | 1 | Square wave offered to the shared pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| alarm_int_n | output | 1 | Shared low-true interrupt / square-wave pin |

## Verification
The hardest case to reach is a status write that lands in the same cycle as a matching tick. Firmware normally clears flags between seconds, so the two rarely meet. The bench drives the write strobe and the tick pulse on one edge, then reads status to confirm the set won. A second hard case is the combination of a flag that is set while the pin stays high. The bench reaches it by letting alarm 1 match with its enable clear, and by clearing alarm 0's enable after it has fired. A cycle-level reference model checks the pin on every clock throughout.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int NUM_ALARMS = 2;
  localparam int FIELDS     = 4;
  localparam int DW         = 8;
  localparam int AW         = 4;
  localparam int MASK_BIT   = DW - 1;
  localparam int ROUTE_BIT  = 2;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_ALARMS * FIELDS);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_ALARMS * FIELDS + 1);
  localparam logic [DW-1:0] CTRL_RESET = DW'(1 << ROUTE_BIT);

  // One field agrees if masked or if its value bits equal the live count.
  function automatic logic field_ok(input logic [DW-1:0] areg,
                                    input logic [DW-1:0] live);
    return areg[MASK_BIT] || (areg[MASK_BIT-1:0] == live[MASK_BIT-1:0]);
  endfunction

  function automatic logic [AW-1:0] alarm_addr(input int alarm, input int field);
    return AW'(alarm * FIELDS + field);
  endfunction

endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int W = DW,
  parameter int F = FIELDS
) (
  input  logic [F-1:0][W-1:0] areg,
  input  logic [F-1:0][W-1:0] live,
  output logic                hit
);

  logic [F-1:0] fld_ok;

  for (genvar f = 0; f < F; f++) begin : g_field
    assign fld_ok[f] = field_ok(areg[f], live[f]);
  end

  assign hit = &fld_ok;

endmodule

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int NA = NUM_ALARMS,
  parameter int F  = FIELDS,
  parameter int W  = DW,
  parameter int A  = AW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [A-1:0]               addr,
  input  logic [W-1:0]               wdata,
  input  logic [NA-1:0]              set_flags,
  output logic [NA-1:0][F-1:0][W-1:0] bank,
  output logic [NA-1:0]              ie,
  output logic                       route,
  output logic [NA-1:0]              flags,
  output logic [W-1:0]               rdata
);

  logic ctrl_wr;
  logic stat_wr;

  assign ctrl_wr = we && (addr == CTRL_ADDR);
  assign stat_wr = we && (addr == STAT_ADDR);

  // Alarm bytes deliberately carry no reset.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int a = 0; a < NA; a++) begin
        for (int f = 0; f < F; f++) begin
          if (addr == alarm_addr(a, f)) bank[a][f] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= CTRL_RESET[NA-1:0];
      route <= CTRL_RESET[ROUTE_BIT];
    end else if (ctrl_wr) begin
      ie    <= wdata[NA-1:0];
      route <= wdata[ROUTE_BIT];
    end
  end

  // A match in the same cycle as a clearing write wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (stat_wr ? (flags & wdata[NA-1:0]) : flags) | set_flags;
    end
  end

  always_comb begin
    rdata = '0;
    for (int a = 0; a < NA; a++) begin
      for (int f = 0; f < F; f++) begin
        if (addr == alarm_addr(a, f)) rdata = bank[a][f];
      end
    end
    if (addr == CTRL_ADDR) begin
      rdata[NA-1:0]     = ie;
      rdata[ROUTE_BIT]  = route;
    end
    if (addr == STAT_ADDR) begin
      rdata[NA-1:0] = flags;
    end
  end

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq #(
  parameter int NA = 2
) (
  input  logic [NA-1:0] flags,
  input  logic [NA-1:0] ie,
  input  logic          route,
  input  logic          sqw_in,
  output logic          irq_req,
  output logic          pin_n
);

  assign irq_req = |(flags & ie);
  assign pin_n   = route ? ~irq_req : sqw_in;

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [DW-1:0] live_sec,
  input  logic [DW-1:0] live_min,
  input  logic [DW-1:0] live_hour,
  input  logic [DW-1:0] live_day,
  input  logic          sqw_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_int_n
);

  logic [FIELDS-1:0][DW-1:0]             live_vec;
  logic [NUM_ALARMS-1:0][FIELDS-1:0][DW-1:0] bank;
  logic [NUM_ALARMS-1:0]                 hit;
  logic [NUM_ALARMS-1:0]                 set_flags;
  logic [NUM_ALARMS-1:0]                 ie;
  logic [NUM_ALARMS-1:0]                 flags;
  logic                                  route;
  logic                                  irq_req;

  assign live_vec  = {live_day, live_hour, live_min, live_sec};
  assign set_flags = hit & {NUM_ALARMS{sec_tick}};

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    tod_alarm_match #(.W(DW), .F(FIELDS)) u_match (
      .areg (bank[a]),
      .live (live_vec),
      .hit  (hit[a])
    );
  end

  tod_alarm_regs #(.NA(NUM_ALARMS), .F(FIELDS), .W(DW), .A(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .set_flags (set_flags),
    .bank      (bank),
    .ie        (ie),
    .route     (route),
    .flags     (flags),
    .rdata     (reg_rdata)
  );

  tod_alarm_irq #(.NA(NUM_ALARMS)) u_irq (
    .flags   (flags),
    .ie      (ie),
    .route   (route),
    .sqw_in  (sqw_in),
    .irq_req (irq_req),
    .pin_n   (alarm_int_n)
  );

endmodule

// File: rtl/tod_alarm_unit_chk.sv
module tod_alarm_unit_chk
  import tod_alarm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sec_tick,
  input logic                  reg_we,
  input logic [AW-1:0]         reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic                  sqw_in,
  input logic                  alarm_int_n,
  input logic [NUM_ALARMS-1:0] hit,
  input logic [NUM_ALARMS-1:0] flags,
  input logic [NUM_ALARMS-1:0] ie,
  input logic                  route
);

  logic stat_wr;
  assign stat_wr = reg_we && (reg_addr == STAT_ADDR);

  a_r3_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ((flags & ~$past(flags)) == '0));

  a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && (|hit)) |=> ((flags & $past(hit)) == $past(hit)));

  a_r5_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !sec_tick) |=> (flags == ($past(flags) & $past(reg_wdata[NUM_ALARMS-1:0]))));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !stat_wr) |=> $stable(flags));

  a_r6_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    (route && ((flags & ie) != '0)) |-> !alarm_int_n);

  a_r10_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route && ((flags & ie) == '0)) |-> alarm_int_n);

  a_r7_sqw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !route |-> (alarm_int_n == sqw_in));

endmodule

bind tod_alarm_unit tod_alarm_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .sqw_in      (sqw_in),
  .alarm_int_n (alarm_int_n),
  .hit         (hit),
  .flags       (flags),
  .ie          (ie),
  .route       (route)
);

// File: tb/tod_alarm_unit_bench.sv
`timescale 1ns/1ps
module tod_alarm_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] live_sec = '0, live_min = '0, live_hour = '0, live_day = '0;
  logic       sqw_in = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_int_n;

  int total = 0;
  int bad   = 0;
  bit started = 0;
  bit done = 0;

  // Behavioural reference state
  int m_al [2][4];
  int m_ie, m_route, m_flag, setv;
  bit ok;

  always #2.5 clk = ~clk;

  tod_alarm_unit u_tod_alarm_unit (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour), .live_day(live_day),
    .sqw_in(sqw_in), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_int_n(alarm_int_n)
  );

  function automatic int live_of(int f);
    case (f)
      0: return int'(live_sec);
      1: return int'(live_min);
      2: return int'(live_hour);
      default: return int'(live_day);
    endcase
  endfunction

  always @(posedge clk) begin
    setv = 0;
    if (rst_n && sec_tick) begin
      for (int a = 0; a < 2; a++) begin
        ok = 1;
        for (int f = 0; f < 4; f++)
          if (!(m_al[a][f] >= 128 || (m_al[a][f] % 128) == (live_of(f) % 128))) ok = 0;
        if (ok) setv = setv + (1 << a);
      end
    end
    if (reg_we && reg_addr < 8) m_al[reg_addr / 4][reg_addr % 4] = int'(reg_wdata);
    if (!rst_n) begin
      m_ie = 0; m_route = 1; m_flag = 0;
    end else begin
      if (reg_we && reg_addr == 8) begin
        m_ie = int'(reg_wdata) % 4; m_route = (int'(reg_wdata) / 4) % 2;
      end
      if (reg_we && reg_addr == 9) m_flag = m_flag & int'(reg_wdata);
      m_flag = (m_flag | setv) % 4;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock pin comparison against the model (R6 and R7)
  always @(negedge clk) begin
    if (started && rst_n && !done)
      chk("R6 R7 pin vs model", int'(alarm_int_n),
          m_route != 0 ? (((m_flag & m_ie) != 0) ? 0 : 1) : int'(sqw_in));
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk); #1;
    reg_addr = 4'(a);
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic set_live(int s, int m, int h, int d);
    live_sec = 8'(s); live_min = 8'(m); live_hour = 8'(h); live_day = 8'(d);
  endtask

  task automatic tk(int s, int m, int h, int d);
    @(negedge clk); #1;
    set_live(s, m, h, d); sec_tick = 1'b1;
    @(negedge clk); #1;
    sec_tick = 1'b0;
  endtask

  task automatic pin(int exp, string req);
    @(negedge clk); #1;
    chk(req, int'(alarm_int_n), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    started = 1;
    // R1 reset state
    rd(8, 8'h04, "R1 control reset");
    rd(9, 8'h00, "R1 status reset");
    pin(1, "R1 pin idle");

    // R9 storage and map
    wr(0, 8'h00); wr(1, 8'h30); wr(2, 8'h45); wr(3, 8'h80);
    wr(4, 8'h12); wr(5, 8'h34); wr(6, 8'h56); wr(7, 8'h07);
    rd(1, 8'h30, "R9 alarm0 minutes");
    rd(3, 8'h80, "R9 alarm0 day with mask bit");
    rd(7, 8'h07, "R9 alarm1 day");
    wr(15, 8'hAA);
    rd(15, 8'h00, "R9 unmapped address");
    wr(8, 8'hFF);
    rd(8, 8'h07, "R9 control upper bits zero");
    wr(8, 8'h05);
    wr(9, 8'h00);
    rd(9, 8'h00, "R9 status cleared");

    // R3 no match, and match without tick
    tk(8'h01, 8'h30, 8'h45, 8'h03);
    rd(9, 8'h00, "R3 mismatched seconds");
    @(negedge clk); #1 set_live(8'h00, 8'h30, 8'h45, 8'h03);
    repeat (3) @(negedge clk);
    rd(9, 8'h00, "R3 match held without tick");

    // R3/R4 daily match with day masked, R6 pin
    tk(8'h00, 8'h30, 8'h45, 8'h03);
    rd(9, 8'h01, "R4 day masked match sets flag");
    pin(0, "R6 pin low on enabled flag");

    // R5/R8 clear via write of 02h, rearm
    wr(9, 8'h02);
    rd(9, 8'h00, "R5 write zero clears flag");
    pin(1, "R8 pin released after clear");
    tk(8'h00, 8'h30, 8'h45, 8'h09);
    rd(9, 8'h01, "R8 still armed for next match");

    // R3 flag set with enable off
    tk(8'h12, 8'h34, 8'h56, 8'h07);
    rd(9, 8'h03, "R3 flag set with enable off");
    pin(0, "R6 pin low");

    // R10 drop enable
    wr(8, 8'h04);
    pin(1, "R10 pin released by enable clear");
    rd(9, 8'h03, "R10 flags kept");

    // R7 square wave routing
    wr(8, 8'h01);
    @(negedge clk); #1 sqw_in = 1'b1;
    pin(1, "R7 pin follows sqw high");
    @(negedge clk); #1 sqw_in = 1'b0;
    pin(0, "R7 pin follows sqw low");
    wr(8, 8'h05);
    wr(9, 8'h01);
    rd(9, 8'h01, "R5 write one keeps flag");
    wr(9, 8'h00);

    // R4 all fields masked on alarm1, partial mask on alarm0
    wr(4, 8'h80); wr(5, 8'h80); wr(6, 8'h80); wr(7, 8'h80);
    tk(8'h11, 8'h22, 8'h33, 8'h44);
    rd(9, 8'h02, "R4 all masked fires");
    wr(9, 8'h00);
    tk(8'h12, 8'h23, 8'h34, 8'h45);
    rd(9, 8'h02, "R4 all masked fires each tick");
    wr(0, 8'h80);
    wr(9, 8'h00);
    tk(8'h27, 8'h30, 8'h45, 8'h01);
    rd(9, 8'h03, "R4 seconds masked match");

    // R5 clearing write collides with matching tick
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h00;
    set_live(8'h05, 8'h06, 8'h07, 8'h08); sec_tick = 1'b1;
    @(negedge clk); #1;
    reg_we = 1'b0; sec_tick = 1'b0;
    rd(9, 8'h02, "R5 tick wins over clear");

    // R2 alarm bytes survive reset
    wr(0, 8'h5A);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    rd(0, 8'h5A, "R2 alarm byte kept over reset");
    rd(6, 8'h80, "R2 alarm1 hours kept");
    rd(8, 8'h04, "R1 control after second reset");
    rd(9, 8'h00, "R1 status after second reset");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule